// File: doc/BRIEF.md
# Block Peak Detector with Hysteresis

This block watches a converter's output stream in a clock domain that runs at one eighth of the sample rate, so every clock brings eight parallel samples. It splits the stream into blocks of a programmable number of clock cycles. Over each block it tracks the largest absolute sample amplitude, scaled onto a 0..256 range where 256 stands for full scale.

When a block ends, the block compares its peak against four programmable levels. These levels form two hysteresis pairs. One pair drives a "signal high" indicator and the other a "signal low" indicator. The block then issues a one-cycle result strobe with the indicator bits and the scaled peak.

A downstream crossing-rate filter or alarm path takes the result bits. They come in either a single-bit form (high only) or a two-bit form (high and low). Software writes the configuration, then pulses the synchronous reset, then raises the enable.

Top module: `pkd_top`

## Requirements
- R1: A synchronous reset clears the result strobe, the result bits, the reported peak, both indicators and the position within the block. All of them read zero after reset.
- R2: Each clock carries eight lanes of 14-bit two's complement samples. Lane k occupies bits [14k+13:14k] of the sample bus. The block peak is the largest of (|sample| >> 5) over every lane and every cycle of the block. The range is 0..256, and a sample of -8192 gives 256.
- R3: The 17-bit block length N sets a block of N consecutive enabled cycles, from 1 up to 65536. A value of 0 acts as 1. The strobe is high for exactly one cycle, in the cycle that follows the block's last sample cycle.
- R4: Blocks follow back to back while enable stays high. The cycle after a block's last cycle is the first cycle of the next block, and the peak of the next block starts from zero.
- R5: The high indicator becomes 1 when the block peak is strictly greater than the high-set level. It becomes 0 when the peak is strictly below the high-clear level. Otherwise it keeps its value. A peak equal to a level causes no change.
- R6: The low indicator becomes 1 when the block peak is strictly below the low-set level. It becomes 0 when the peak is strictly greater than the low-clear level. Otherwise it keeps its value.
- R7: In two-bit mode, result bit 1 is the high indicator and bit 0 is the low indicator. In one-bit mode, bit 0 is the high indicator and bit 1 is 0. The result bits and peak change only together with a strobe.
- R8: While enable is low, no strobe occurs, the outputs hold and the partial block is discarded. A block then begins on the first cycle enable is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at one eighth of the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Detection runs while high |
| twoBitMode | input | 1 | 1 selects the two-bit result form |
| blockLen | input | 17 | Block length in clock cycles (0 acts as 1) |
| thrHiSet | input | 9 | Level above which the high indicator sets |
| thrHiClr | input | 9 | Level below which the high indicator clears |
| thrLoSet | input | 9 | Level below which the low indicator sets |
| thrLoClr | input | 9 | Level above which the low indicator clears |
| samples | input | 112 | Eight 14-bit two's complement samples |
| resultStrobe | output | 1 | One-cycle pulse at the end of each block |
| resultBits | output | 2 | Indicator bits of the last finished block |
| blockPeak | output | 9 | Scaled peak of the last finished block |

## Verification
The bench walks the hysteresis through set, hold, clear and exact-equality peaks. A design that used non-strict compares, or that forgot to hold, would flip an indicator on the wrong block. Blocks run back to back, including one-cycle blocks, the zero length and the 65536 maximum. An off-by-one counter, or an accumulator that missed the first cycle of each block or carried the previous peak over, would shift the strobe or report a stale peak. The peak is moved across every lane and block position, and a block holds the most negative code. An absolute-value stage that overflowed there, or a dead lane, would show a wrong peak. Enable is dropped in the middle of a block with a large sample pending. A design that kept that partial block would report the discarded peak.

// File: rtl/pkd_pkg.sv
package pkd_pkg;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic clearAcc;   // detection idle: drop the partial block
    logic endBlock;   // this cycle is the last one of the block
  } pkdStrobes_t;

endpackage

// File: rtl/pkd_ctrl.sv
module pkd_ctrl
  import pkd_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [LEN_W-1:0] blockLen,
  output pkdStrobes_t      strb
);

  logic [LEN_W-1:0] blockPos;
  logic [LEN_W-1:0] lastPos;
  logic             atLast;

  // A length of zero behaves as a one-cycle block
  assign lastPos = (blockLen == '0) ? '0 : blockLen - LEN_W'(1);
  assign atLast  = (blockPos >= lastPos);

  assign strb.clearAcc = ~enable;
  assign strb.endBlock = enable & atLast;

  always_ff @(posedge clk) begin
    if (rst || !enable || atLast) begin
      blockPos <= '0;
    end else begin
      blockPos <= blockPos + LEN_W'(1);
    end
  end

  // R3: the position never runs past the last cycle while the length is steady
  a_r3_pos_bound: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable) && $stable(blockLen)) |-> (blockPos <= lastPos));

  // R8: the position rests at zero while detection is idle
  a_r8_idle_pos: assert property (@(posedge clk) disable iff (rst)
    $past(!enable) |-> (blockPos == '0));

endmodule

// File: rtl/pkd_datapath.sv
module pkd_datapath
  import pkd_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int SAMPLE_W = 14,
  parameter int PEAK_W   = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  pkdStrobes_t               strb,
  input  logic                      twoBitMode,
  input  logic [PEAK_W-1:0]         thrHiSet,
  input  logic [PEAK_W-1:0]         thrHiClr,
  input  logic [PEAK_W-1:0]         thrLoSet,
  input  logic [PEAK_W-1:0]         thrLoClr,
  input  logic [LANES*SAMPLE_W-1:0] samples,
  output logic                      resultStrobe,
  output logic [1:0]                resultBits,
  output logic [PEAK_W-1:0]         blockPeak
);

  localparam int FULL_SCALE = 1 << (PEAK_W - 1);

  logic [PEAK_W-1:0] laneMag [LANES];
  logic [PEAK_W-1:0] cycleMax;
  logic [PEAK_W-1:0] peakAcc;
  logic [PEAK_W-1:0] peakNow;
  logic              hiInd;
  logic              loInd;
  logic              hiNext;
  logic              loNext;

  // Per-lane magnitude, truncated to the top bits of the sample width
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SAMPLE_W-1:0] raw;
    logic [SAMPLE_W-1:0] mag;
    assign raw = samples[g*SAMPLE_W +: SAMPLE_W];
    assign mag = raw[SAMPLE_W-1] ? (~raw + SAMPLE_W'(1)) : raw;
    assign laneMag[g] = mag[SAMPLE_W-1 -: PEAK_W];
  end

  always_comb begin
    cycleMax = '0;
    for (int i = 0; i < LANES; i++) begin
      if (laneMag[i] > cycleMax) cycleMax = laneMag[i];
    end
  end

  assign peakNow = (cycleMax > peakAcc) ? cycleMax : peakAcc;

  // Hysteresis update from the finished block's peak
  always_comb begin
    hiNext = hiInd;
    if (peakNow > thrHiSet)      hiNext = 1'b1;
    else if (peakNow < thrHiClr) hiNext = 1'b0;
    loNext = loInd;
    if (peakNow < thrLoSet)      loNext = 1'b1;
    else if (peakNow > thrLoClr) loNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      peakAcc      <= '0;
      hiInd        <= 1'b0;
      loInd        <= 1'b0;
      resultStrobe <= 1'b0;
      resultBits   <= 2'b00;
      blockPeak    <= '0;
    end else begin
      resultStrobe <= strb.endBlock;
      if (strb.clearAcc || strb.endBlock) peakAcc <= '0;
      else                                peakAcc <= peakNow;
      if (strb.endBlock) begin
        hiInd      <= hiNext;
        loInd      <= loNext;
        blockPeak  <= peakNow;
        resultBits <= twoBitMode ? {hiNext, loNext} : {1'b0, hiNext};
      end
    end
  end

  // R2: a reported peak never exceeds full scale
  a_r2_peak_range: assert property (@(posedge clk) disable iff (rst)
    resultStrobe |-> (blockPeak <= PEAK_W'(FULL_SCALE)));

  // R5: the high indicator only rises on a peak above the set level
  a_r5_high_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(hiInd) |-> (blockPeak > $past(thrHiSet)));

  // R6: the low indicator only rises on a peak below the set level
  a_r6_low_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(loInd) |-> (blockPeak < $past(thrLoSet)));

  // R7: results move only together with a strobe
  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    !resultStrobe |-> ($stable(resultBits) && $stable(blockPeak)));

  // R8: no strobe follows an idle cycle
  a_r8_no_idle_strobe: assert property (@(posedge clk) disable iff (rst)
    resultStrobe |-> $past(!strb.clearAcc));

endmodule

// File: rtl/pkd_top.sv
module pkd_top
  import pkd_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int SAMPLE_W = 14,
  parameter int PEAK_W   = 9,
  parameter int LEN_W    = 17
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      enable,
  input  logic                      twoBitMode,
  input  logic [LEN_W-1:0]          blockLen,
  input  logic [PEAK_W-1:0]         thrHiSet,
  input  logic [PEAK_W-1:0]         thrHiClr,
  input  logic [PEAK_W-1:0]         thrLoSet,
  input  logic [PEAK_W-1:0]         thrLoClr,
  input  logic [LANES*SAMPLE_W-1:0] samples,
  output logic                      resultStrobe,
  output logic [1:0]                resultBits,
  output logic [PEAK_W-1:0]         blockPeak
);

  pkdStrobes_t strb;

  pkd_ctrl #(
    .LEN_W (LEN_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .blockLen (blockLen),
    .strb     (strb)
  );

  pkd_datapath #(
    .LANES    (LANES),
    .SAMPLE_W (SAMPLE_W),
    .PEAK_W   (PEAK_W)
  ) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .twoBitMode   (twoBitMode),
    .thrHiSet     (thrHiSet),
    .thrHiClr     (thrHiClr),
    .thrLoSet     (thrLoSet),
    .thrLoClr     (thrLoClr),
    .samples      (samples),
    .resultStrobe (resultStrobe),
    .resultBits   (resultBits),
    .blockPeak    (blockPeak)
  );

endmodule

// File: tb/pkd_top_tb.sv
module pkd_top_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enable = 1'b0;
  logic         twoBitMode = 1'b1;
  logic [16:0]  blockLen = 17'd4;
  logic [8:0]   thrHiSet = 9'd203;
  logic [8:0]   thrHiClr = 9'd150;
  logic [8:0]   thrLoSet = 9'd40;
  logic [8:0]   thrLoClr = 9'd60;
  logic [111:0] samples = '0;
  logic         resultStrobe;
  logic [1:0]   resultBits;
  logic [8:0]   blockPeak;

  int nChecks = 0;
  int nFails  = 0;
  bit mHi = 1'b0;
  bit mLo = 1'b0;
  int mBits = 0;
  int mPeak = 0;

  always #10 clk = ~clk;

  pkd_top u_dut (
    .clk(clk), .rst(rst), .enable(enable), .twoBitMode(twoBitMode),
    .blockLen(blockLen), .thrHiSet(thrHiSet), .thrHiClr(thrHiClr),
    .thrLoSet(thrLoSet), .thrLoClr(thrLoClr), .samples(samples),
    .resultStrobe(resultStrobe), .resultBits(resultBits), .blockPeak(blockPeak)
  );

  function automatic int scaled(input int v);
    int a;
    a = (v < 0) ? -v : v;
    return a >> 5;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic driveCycle(input int cyc, input int peakCyc, input int lane, input int val);
    for (int l = 0; l < 8; l++) begin
      int v;
      v = (cyc == peakCyc && l == lane) ? val : ((l % 2) ? 5 : -5);
      samples[l*14 +: 14] = 14'(v);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mHi = 1'b0; mLo = 1'b0; mBits = 0; mPeak = 0;
  endtask

  // Runs n blocks back to back; checks each strobe, the gaps and the results
  task automatic doBlocks(input int len, input int n, input int vals[8], input string tag);
    int effLen;
    effLen = (len == 0) ? 1 : len;
    blockLen = 17'(len);
    for (int t = 0; t <= n * effLen; t++) begin
      @(negedge clk);
      if (t > 0) begin
        if (t % effLen == 0) begin
          int b;
          int p;
          b = t / effLen - 1;
          p = scaled(vals[b]);
          if (p > thrHiSet) mHi = 1'b1;
          else if (p < thrHiClr) mHi = 1'b0;
          if (p < thrLoSet) mLo = 1'b1;
          else if (p > thrLoClr) mLo = 1'b0;
          mBits = twoBitMode ? {30'd0, mHi, mLo} : {31'd0, mHi};
          mPeak = p;
          check("R3", {tag, " strobe at block end"}, int'(resultStrobe), 1);
          check("R2", {tag, " block peak"}, int'(blockPeak), mPeak);
          check((mHi || !mLo) ? "R5" : "R6", {tag, " indicator bits"}, int'(resultBits), mBits);
        end else begin
          check("R4", {tag, " no strobe inside block"}, int'(resultStrobe), 0);
        end
      end
      if (t < n * effLen) begin
        int b;
        b = t / effLen;
        enable = 1'b1;
        driveCycle(t % effLen, (b * 5 + 2) % effLen, (b * 3 + 1) % 8, vals[b]);
      end else begin
        enable = 1'b0;
      end
    end
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    check("R1", "strobe after reset", int'(resultStrobe), 0);
    check("R1", "bits after reset", int'(resultBits), 0);
    check("R1", "peak after reset", int'(blockPeak), 0);
  endtask

  task automatic testHysteresisTwoBit();
    doReset();
    twoBitMode = 1'b1;
    doBlocks(4, 8, '{210*32+17, -(180*32+3), 140*32+31, 30*32+7,
                     -(50*32), 70*32+1, -(203*32+31), -8192}, "R5 R6 hysteresis");
  endtask

  task automatic testOneBit();
    doReset();
    twoBitMode = 1'b0;
    doBlocks(3, 4, '{-(220*32), 30*32, 100*32, 10*32, 0, 0, 0, 0}, "R7 one-bit");
    twoBitMode = 1'b1;
  endtask

  task automatic testShortBlocks();
    doReset();
    doBlocks(1, 8, '{8191, -1, 64, -8192, 33*32, 255*32, -(7*32), 12}, "R4 length one");
    doBlocks(0, 3, '{-(90*32), 250*32, 5*32, 0, 0, 0, 0, 0}, "R3 length zero");
  endtask

  task automatic testLongBlocks();
    doReset();
    doBlocks(300, 2, '{-(240*32), 45*32, 0, 0, 0, 0, 0, 0}, "R2 length 300");
    doBlocks(65536, 1, '{-(35*32+9), 0, 0, 0, 0, 0, 0, 0}, "R3 length max");
  endtask

  task automatic testEnableAbort();
    doReset();
    blockLen = 17'd6;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      enable = 1'b1;
      driveCycle(c, 1, 4, 8000);
    end
    @(negedge clk);
    enable = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      check("R8", "no strobe while idle", int'(resultStrobe), 0);
      check("R8", "bits hold while idle", int'(resultBits), 0);
    end
    doBlocks(6, 1, '{100*32, 0, 0, 0, 0, 0, 0, 0}, "R8 restart after abort");
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    testReset();
    testHysteresisTwoBit();
    testOneBit();
    testShortBlocks();
    testLongBlocks();
    testEnableAbort();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule